// File: doc/BRIEF.md
# Four-Channel Converter Serial Load Controller

This block is the digital front end of a four-channel, 16-bit converter. A host sends command frames over a serial link made of a clock, a data line and an active-low frame-select. Each frame carries a channel address, a register-select field and a 16-bit value. Frames that are complete and well formed write the addressed channel. The analog conversion path reads each channel's active code from a parallel output.

A load line chooses how a code write reaches the outputs. If the load line is low when a frame closes, the addressed channel takes the new code at once. If the load line is high, the write is held as a pending value. Every channel that has a pending value takes it in the same cycle when the load line falls. While the load line stays high, only the first write to each channel is held; later writes to that channel do not change what is transferred.

A checksum mode adds an 8-bit CRC to each frame. A frame that fails the checksum is dropped and sets a sticky error flag. A clear input forces every channel that has its clear enabled to a shared clear code. After reset, all frames are ignored for a fixed number of cycles, which covers the converter's start-up calibration time. The serial inputs are assumed to be already synchronous to the system clock, which oversamples them.

Top module: `dac_load_ctrl`

## Requirements
- R1: Serial data is shifted in MSB first, one bit on each falling edge of `spi_sclk` seen while `spi_sel_n` is low. A frame closes when `spi_sel_n` rises. Without checksum a frame has 24 bits. Bit 23 is reserved and must be 0, bits 22:21 address the channel, bits 20:16 select the register, and bits 15:0 carry the value.
- R2: If `load` is low when a frame with register select 0 closes, the addressed channel's code on `dac_codes` (channel n at bits 16n+15:16n) is updated on the first clock edge that sees `spi_sel_n` high.
- R3: If `load` is high when a register-select-0 frame closes, no output changes. On the clock edge that sees `load` go from high to low, every channel with a pending write takes its pending value, all in the same cycle.
- R4: While `load` stays high, only the first register-select-0 write to each channel becomes pending, and later writes to that channel are not transferred. The per-channel first-write flag clears when the transfer on a falling `load` happens and when `load` rises.
- R5: After reset, all channel codes, the clear code, every clear enable and `crc_err` are zero.
- R6: While `clear` is high, each channel whose clear enable is set takes the clear code. Register select 1 writes the clear code from bits 15:0. Register select 2 writes the addressed channel's clear enable from bit 0.
- R7: A frame whose bit count at close is not exactly 24 (checksum off) or 32 (checksum on) is discarded and changes no state.
- R8: With `crc_en` high, a frame holds 24 payload bits followed by an 8-bit CRC. The CRC uses polynomial x^8+x^2+x+1, starts from zero and runs MSB first. On a mismatch the frame is discarded and `crc_err` is set and stays set until reset.
- R9: For HOLDOFF_CYC cycles after reset is released, every frame is ignored.
- R10: A frame with bit 23 set or with a register select other than 0, 1 or 2 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_en | input | 1 | Enables the trailing checksum byte |
| spi_sclk | input | 1 | Serial clock, sampled by clk |
| spi_mosi | input | 1 | Serial data in |
| spi_sel_n | input | 1 | Active-low frame select |
| load | input | 1 | Load line: low = immediate update, falling = group update |
| clear | input | 1 | Applies the clear code to clear-enabled channels |
| dac_codes | output | 64 | Active codes, channel n at bits 16n+15:16n |
| crc_err | output | 1 | Sticky checksum mismatch flag |

## Verification
Every result is due on the first clock edge after its cause is seen at the inputs. A frame takes effect at the edge that first sees `spi_sel_n` high, a group update at the edge that first sees `load` low, and a clear at the edge that sees `clear` high. The bench changes inputs on the falling clock edge and reads outputs on the next falling edge after that one rising edge. This places each check exactly one cycle after its stimulus. Each discard case is read at the same point, and the outputs must still hold their previous codes.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;

    localparam int NCH     = 4;
    localparam int CODE_W  = 16;
    localparam int PAY_W   = 24;
    localparam int CRC_W   = 8;
    localparam int FRM_MAX = PAY_W + CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [4:0] {
        SEL_CODE    = 5'h00,
        SEL_CLRCODE = 5'h01,
        SEL_CLREN   = 5'h02
    } regsel_e;

    typedef struct packed {
        logic              rsvd;
        logic [1:0]        chan;
        logic [4:0]        sel;
        logic [CODE_W-1:0] value;
    } cmd_word_t;

    function automatic logic [CRC_W-1:0] crc8_calc(input logic [PAY_W-1:0] pay);
        logic [CRC_W-1:0] r;
        r = '0;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ pay[i]) r = (r << 1) ^ CRC_POLY;
            else                      r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
    parameter int MAXBITS = 32,
    localparam int CNT_W = $clog2(MAXBITS + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk,
    input  logic               mosi,
    input  logic               sel_n,
    output logic               frame_end,
    output logic [MAXBITS-1:0] shreg,
    output logic [CNT_W-1:0]   nbits
);
    logic sclk_q;
    logic sel_q;

    assign frame_end = !sel_q && sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b1;
            sel_q  <= 1'b1;
            shreg  <= '0;
            nbits  <= '0;
        end else begin
            sclk_q <= sclk;
            sel_q  <= sel_n;
            if (sel_n) begin
                if (sel_q) nbits <= '0;
            end else if (sclk_q && !sclk) begin
                shreg <= {shreg[MAXBITS-2:0], mosi};
                if (nbits != CNT_W'(MAXBITS + 1)) nbits <= nbits + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot
    import dac_load_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_code,
    input  logic              immediate,
    input  logic [CODE_W-1:0] wr_val,
    input  logic              wr_clren,
    input  logic              clren_val,
    input  logic              load_fall,
    input  logic              load_rise,
    input  logic              clear_go,
    input  logic [CODE_W-1:0] clear_code,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] pend;
    logic              kept;
    logic              clren;

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            pend  <= '0;
            kept  <= 1'b0;
            clren <= 1'b0;
        end else begin
            if (wr_clren) clren <= clren_val;

            if (clear_go && clren)        code <= clear_code;
            else if (load_fall && kept)   code <= pend;
            else if (wr_code && immediate) code <= wr_val;

            if (load_rise || load_fall) begin
                kept <= 1'b0;
            end else if (wr_code && !immediate && !kept) begin
                kept <= 1'b1;
                pend <= wr_val;
            end
        end
    end
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
    import dac_load_pkg::*;
#(
    parameter int HOLDOFF_CYC = 12500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  crc_en,
    input  logic                  spi_sclk,
    input  logic                  spi_mosi,
    input  logic                  spi_sel_n,
    input  logic                  load,
    input  logic                  clear,
    output logic [NCH*CODE_W-1:0] dac_codes,
    output logic                  crc_err
);
    localparam int CNT_W = $clog2(FRM_MAX + 2);
    localparam int HO_W  = $clog2(HOLDOFF_CYC + 1);

    logic               frame_end;
    logic [FRM_MAX-1:0] shreg;
    logic [CNT_W-1:0]   nbits;
    logic [HO_W-1:0]    ho_cnt;
    logic               busy;
    logic               load_q;
    logic               load_fall, load_rise;
    logic               len_ok, crc_ok, accept, good;
    logic [PAY_W-1:0]   payload;
    cmd_word_t          cmd;
    logic [CODE_W-1:0]  clear_code;
    logic [NCH-1:0]     chan_we, chan_clren_we;

    dac_serial_rx #(.MAXBITS(FRM_MAX)) u_rx (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .mosi(spi_mosi),
        .sel_n(spi_sel_n), .frame_end(frame_end), .shreg(shreg), .nbits(nbits)
    );

    assign busy      = (ho_cnt != '0);
    assign load_fall = load_q && !load;
    assign load_rise = !load_q && load;

    always_comb begin
        len_ok  = crc_en ? (nbits == CNT_W'(FRM_MAX)) : (nbits == CNT_W'(PAY_W));
        payload = crc_en ? shreg[FRM_MAX-1:CRC_W] : shreg[PAY_W-1:0];
        crc_ok  = !crc_en || (crc8_calc(payload) == shreg[CRC_W-1:0]);
        cmd     = cmd_word_t'(payload);
        accept  = frame_end && len_ok && !busy;
        good    = accept && crc_ok && !cmd.rsvd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ho_cnt     <= HO_W'(HOLDOFF_CYC);
            load_q     <= 1'b0;
            crc_err    <= 1'b0;
            clear_code <= '0;
        end else begin
            if (busy) ho_cnt <= ho_cnt - 1'b1;
            load_q <= load;
            if (accept && !crc_ok) crc_err <= 1'b1;
            if (good && cmd.sel == SEL_CLRCODE) clear_code <= cmd.value;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign chan_we[c]       = good && cmd.sel == SEL_CODE  && cmd.chan == 2'(c);
        assign chan_clren_we[c] = good && cmd.sel == SEL_CLREN && cmd.chan == 2'(c);

        dac_chan_slot u_slot (
            .clk(clk), .rst(rst),
            .wr_code(chan_we[c]), .immediate(!load), .wr_val(cmd.value),
            .wr_clren(chan_clren_we[c]), .clren_val(cmd.value[0]),
            .load_fall(load_fall), .load_rise(load_rise),
            .clear_go(clear), .clear_code(clear_code),
            .code(dac_codes[c*CODE_W +: CODE_W])
        );
    end
endmodule

// File: rtl/dac_load_ctrl_chk.sv
module dac_load_ctrl_chk
    import dac_load_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  load,
    input logic                  load_q,
    input logic                  clear,
    input logic                  frame_end,
    input logic                  len_ok,
    input logic                  busy,
    input logic [NCH-1:0]        chan_we,
    input logic [NCH*CODE_W-1:0] dac_codes,
    input logic                  crc_err
);
    logic quiet;
    assign quiet = !clear && !(load_q && !load);

    // R5: outputs come out of reset cleared
    a_r5_reset_zero: assert property (@(posedge clk) $fell(rst) |-> (dac_codes == '0 && !crc_err));

    // R3: with load held high and no clear, codes do not move
    a_r3_hold_high: assert property (@(posedge clk) disable iff (rst)
        (load && load_q && !clear) |=> $stable(dac_codes));

    // R7: a wrong-length frame leaves codes and error flag alone
    a_r7_bad_len: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !len_ok && quiet) |=> ($stable(dac_codes) && $stable(crc_err)));

    // R8: error flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        crc_err |=> crc_err);

    // R9: frames during holdoff change nothing
    a_r9_holdoff: assert property (@(posedge clk) disable iff (rst)
        (busy && quiet) |=> ($stable(dac_codes) && $stable(crc_err)));

    // R1: a frame addresses at most one channel
    a_r1_one_chan: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_we));
endmodule

bind dac_load_ctrl dac_load_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .load(load), .load_q(load_q), .clear(clear),
    .frame_end(frame_end), .len_ok(len_ok), .busy(busy), .chan_we(chan_we),
    .dac_codes(dac_codes), .crc_err(crc_err)
);

// File: tb/dac_load_ctrl_bench.sv
`timescale 1ns/1ps
module dac_load_ctrl_bench;
    localparam int HOLD = 12500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        crc_en = 1'b0;
    logic        spi_sclk = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_sel_n = 1'b1;
    logic        load = 1'b0;
    logic        clear = 1'b0;
    logic [63:0] dac_codes;
    logic        crc_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dac_load_ctrl #(.HOLDOFF_CYC(HOLD)) u_dac_load_ctrl (
        .clk(clk), .rst(rst), .crc_en(crc_en), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_sel_n(spi_sel_n), .load(load),
        .clear(clear), .dac_codes(dac_codes), .crc_err(crc_err)
    );

    function automatic logic [15:0] ch_code(input int ch);
        return dac_codes[ch*16 +: 16];
    endfunction

    function automatic logic [23:0] mk(input logic rsv, input logic [1:0] ch,
                                       input logic [4:0] sel, input logic [15:0] v);
        return {rsv, ch, sel, v};
    endfunction

    function automatic logic [7:0] ref_crc(input logic [23:0] p);
        logic [7:0] r = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            logic fb = r[7] ^ p[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shifts n bits MSB first; checks are sampled one edge after sel rises.
    task automatic send(input logic [31:0] bits, input int n, input logic ld);
        @(negedge clk);
        load = ld;
        spi_sel_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            spi_mosi = bits[i];
            spi_sclk = 1'b1;
            repeat (2) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        spi_sclk = 1'b1;
        repeat (2) @(negedge clk);
        spi_sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send24(input logic [23:0] w, input logic ld);
        send({8'h00, w}, 24, ld);
    endtask

    task automatic drop_load;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clear;
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic t_reset;
        chk("R5 codes after reset", dac_codes[31:0], 32'h0);
        chk("R5 codes after reset hi", dac_codes[63:32], 32'h0);
        chk("R5 crc_err after reset", {31'h0, crc_err}, 32'h0);
    endtask

    task automatic t_holdoff;
        send24(mk(1'b0, 2'd0, 5'h00, 16'h1234), 1'b0);
        chk("R9 frame in holdoff ignored", {16'h0, ch_code(0)}, 32'h0);
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic t_immediate;
        logic [15:0] v [4] = '{16'h1111, 16'hA5C3, 16'h8000, 16'hFFFF};
        for (int c = 0; c < 4; c++) send24(mk(1'b0, 2'(c), 5'h00, v[c]), 1'b0);
        for (int c = 0; c < 4; c++) chk("R1 R2 immediate write", {16'h0, ch_code(c)}, {16'h0, v[c]});
    endtask

    task automatic t_simul;
        send24(mk(1'b0, 2'd1, 5'h00, 16'hAAAA), 1'b1);
        chk("R3 no update while load high", {16'h0, ch_code(1)}, 32'hA5C3);
        send24(mk(1'b0, 2'd1, 5'h00, 16'hBBBB), 1'b1);
        send24(mk(1'b0, 2'd2, 5'h00, 16'h5555), 1'b1);
        chk("R3 ch2 held while load high", {16'h0, ch_code(2)}, 32'h8000);
        drop_load();
        chk("R4 first write kept ch1", {16'h0, ch_code(1)}, 32'hAAAA);
        chk("R3 group update ch2", {16'h0, ch_code(2)}, 32'h5555);
        chk("R3 unwritten ch0 unchanged", {16'h0, ch_code(0)}, 32'h1111);
        send24(mk(1'b0, 2'd1, 5'h00, 16'h0F0F), 1'b1);
        drop_load();
        chk("R4 flag cleared after update", {16'h0, ch_code(1)}, 32'h0F0F);
    endtask

    task automatic t_badlen;
        send({9'h0, mk(1'b0, 2'd3, 5'h00, 16'h0001)}[31:0], 23, 1'b0);
        chk("R7 23-bit frame dropped", {16'h0, ch_code(3)}, 32'hFFFF);
        send({7'h0, mk(1'b0, 2'd3, 5'h00, 16'h0002), 1'b0}, 25, 1'b0);
        chk("R7 25-bit frame dropped", {16'h0, ch_code(3)}, 32'hFFFF);
    endtask

    task automatic t_regsel;
        send24(mk(1'b0, 2'd3, 5'h07, 16'h0003), 1'b0);
        chk("R10 unknown select dropped", {16'h0, ch_code(3)}, 32'hFFFF);
        send24(mk(1'b1, 2'd3, 5'h00, 16'h0004), 1'b0);
        chk("R10 reserved bit dropped", {16'h0, ch_code(3)}, 32'hFFFF);
    endtask

    task automatic t_clear;
        pulse_clear();
        chk("R6 clear with no enables", {16'h0, ch_code(0)}, 32'h1111);
        send24(mk(1'b0, 2'd0, 5'h02, 16'h0001), 1'b0);
        pulse_clear();
        chk("R6 R5 clear code zero", {16'h0, ch_code(0)}, 32'h0);
        chk("R6 disabled ch2 untouched", {16'h0, ch_code(2)}, 32'h5555);
        send24(mk(1'b0, 2'd2, 5'h01, 16'h7777), 1'b0);
        pulse_clear();
        chk("R6 new clear code", {16'h0, ch_code(0)}, 32'h7777);
    endtask

    task automatic t_crc;
        logic [23:0] w;
        crc_en = 1'b1;
        w = mk(1'b0, 2'd3, 5'h00, 16'h4321);
        send({w, ref_crc(w)}, 32, 1'b0);
        chk("R8 good crc frame", {16'h0, ch_code(3)}, 32'h4321);
        chk("R8 no error on good", {31'h0, crc_err}, 32'h0);
        send24(mk(1'b0, 2'd3, 5'h00, 16'h1357), 1'b0);
        chk("R7 24 bits with crc on dropped", {16'h0, ch_code(3)}, 32'h4321);
        w = mk(1'b0, 2'd3, 5'h00, 16'h2468);
        send({w, ref_crc(w) ^ 8'h01}, 32, 1'b0);
        chk("R8 bad crc dropped", {16'h0, ch_code(3)}, 32'h4321);
        chk("R8 error set", {31'h0, crc_err}, 32'h1);
        w = mk(1'b0, 2'd1, 5'h00, 16'h9999);
        send({w, ref_crc(w)}, 32, 1'b0);
        chk("R8 good after bad", {16'h0, ch_code(1)}, 32'h9999);
        chk("R8 error sticky", {31'h0, crc_err}, 32'h1);
        crc_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_holdoff();
        t_immediate();
        t_simul();
        t_badlen();
        t_regsel();
        t_clear();
        t_crc();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule